// File: doc/BRIEF.md
# Write-Unlock Command Sequencer

This block guards an electrically erasable array against stray programming. Each write is reported to it by the page load controller as a single-cycle strobe carrying the address and data of that write. The block compares the writes against a fixed prefix of three command writes, each with its own address and data value. Only after the full prefix, in order, does it mark the current load window as authorised. The load controller then commits the data bytes it gathers. If the window is not authorised, the controller still runs the programming timer but discards the data.

The three command writes are flagged as they arrive so the load controller does not place them in the page buffer. Their addresses stay ordinary locations for later data writes. A mismatch at any step returns the matcher to its first step, and the mismatching write counts as an unauthorised write. Authorisation lasts for one write operation only. It is dropped when the programming cycle reports completion, so every operation must start with the prefix again. The command addresses and data values are parameters.

Top module: `sdp_unlock_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, auth_o is 0. cmd_o is 0 whenever wr_stb_i is 0.
- R2: When three strobes in order match (SEQ_ADDR[0],SEQ_DATA[0]), (SEQ_ADDR[1],SEQ_DATA[1]) and (SEQ_ADDR[2],SEQ_DATA[2]), auth_o goes to 1 in the cycle after the third strobe. Defaults: 15'h5555/8'hAA, 15'h2AAA/8'h55, 15'h5555/8'hA0.
- R3: cmd_o is 1 in the same cycle as each strobe that matches the expected next step of the prefix while auth_o is 0.
- R4: A strobe whose address or data differs from the expected step gives cmd_o = 0 and leaves auth_o at 0. It also returns the matcher to step 0, so the prefix must be restarted from its first write.
- R5: While auth_o is 1, strobes give cmd_o = 0, even when they match a command value. auth_o stays 1.
- R6: auth_o stays 1 across any number of writes and idle cycles until cycle_done_i is 1. It is then 0 from the following cycle.
- R7: A cycle_done_i pulse during a partly matched prefix discards the progress.
- R8: A strobe in the same cycle as cycle_done_i gives cmd_o = 0 and does not advance the prefix.
- R9: Cycles without a strobe leave the prefix progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | One-cycle pulse per host write |
| wr_addr_i | input | ADDR_W | Address of the write |
| wr_data_i | input | DATA_W | Data of the write |
| cycle_done_i | input | 1 | Pulse at the end of a programming cycle |
| auth_o | output | 1 | Current load window may be committed |
| cmd_o | output | 1 | Present strobe is a command write; do not load it |

## Verification
The matcher is driven with a clean prefix, with the prefix split by idle gaps, and with a wrong data value and a wrong address at the second and third steps. These cases show that a failed step restarts from the first write, rather than retrying the same step or skipping ahead. Writes that reuse a command value after arming show whether command flagging stops once the window is open. A completion pulse is placed at several points: alone in the middle of the prefix, together with the final command strobe, and together with a data strobe while armed. These placements separate clearing of progress from clearing of authorisation, and show that completion takes priority over a strobe in the same cycle.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic {PH_SEEK = 1'b0, PH_ARMED = 1'b1} phase_e;
endpackage

// File: rtl/sdp_step_match.sv
module sdp_step_match #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int NSTEP  = 3,
  parameter logic [NSTEP-1:0][ADDR_W-1:0] SEQ_ADDR = '0,
  parameter logic [NSTEP-1:0][DATA_W-1:0] SEQ_DATA = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NSTEP-1:0]  hit_o
);
  for (genvar i = 0; i < NSTEP; i++) begin : g_cmp
    assign hit_o[i] = (addr_i == SEQ_ADDR[i]) && (data_i == SEQ_DATA[i]);
  end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
#(
  parameter int NSTEP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             done_i,
  input  logic [NSTEP-1:0] hit_i,
  output logic             armed_o,
  output logic             cmd_o
);
  localparam int STEP_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic              step_hit;

  assign step_hit = hit_i[step_q];
  // done has priority: a coincident strobe never counts toward the prefix
  assign cmd_o    = stb_i && !done_i && (phase_q == PH_SEEK) && step_hit;
  assign armed_o  = (phase_q == PH_ARMED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SEEK;
      step_q  <= '0;
    end else if (done_i) begin
      phase_q <= PH_SEEK;
      step_q  <= '0;
    end else if (stb_i && phase_q == PH_SEEK) begin
      if (!step_hit) begin
        step_q <= '0;
      end else if (step_q == LAST) begin
        step_q  <= '0;
        phase_q <= PH_ARMED;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdp_unlock_seq.sv
module sdp_unlock_seq #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int NSTEP  = 3,
  parameter logic [NSTEP-1:0][ADDR_W-1:0] SEQ_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [NSTEP-1:0][DATA_W-1:0] SEQ_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cycle_done_i,
  output logic              auth_o,
  output logic              cmd_o
);
  logic [NSTEP-1:0] hit;

  sdp_step_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTEP(NSTEP),
    .SEQ_ADDR(SEQ_ADDR), .SEQ_DATA(SEQ_DATA)
  ) u_match (
    .addr_i(wr_addr_i),
    .data_i(wr_data_i),
    .hit_o (hit)
  );

  sdp_seq_fsm #(.NSTEP(NSTEP)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (wr_stb_i),
    .done_i (cycle_done_i),
    .hit_i  (hit),
    .armed_o(auth_o),
    .cmd_o  (cmd_o)
  );
endmodule

// File: rtl/sdp_unlock_seq_chk.sv
module sdp_unlock_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_stb_i,
  input logic cycle_done_i,
  input logic auth_o,
  input logic cmd_o
);
  assert_cmd_needs_stb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |-> wr_stb_i);

  assert_rise_after_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(auth_o) |-> $past(cmd_o));

  assert_mismatch_no_auth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !cmd_o && !auth_o) |=> !auth_o);

  assert_no_cmd_when_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auth_o |-> !cmd_o);

  assert_auth_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auth_o && !cycle_done_i) |=> auth_o);

  assert_done_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_i |=> !auth_o);

  assert_done_blocks_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_i |-> !cmd_o);
endmodule

bind sdp_unlock_seq sdp_unlock_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_stb_i    (wr_stb_i),
  .cycle_done_i(cycle_done_i),
  .auth_o      (auth_o),
  .cmd_o       (cmd_o)
);

// File: tb/sdp_unlock_seq_tb.sv
module sdp_unlock_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  data = '0;
  logic        done = 1'b0;
  logic        auth, cmd;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdp_unlock_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(stb), .wr_addr_i(addr),
    .wr_data_i(data), .cycle_done_i(done), .auth_o(auth), .cmd_o(cmd)
  );

  // {stb, done, addr, data, exp_cmd, exp_auth_next, req}
  localparam int NV = 27;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd3},  // R3 step 0
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 4'd3},  // R3 step 1
    {1'b0, 1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 gap
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b1, 1'b1, 4'd2},  // R2 armed
    {1'b1, 1'b0, 15'h1234, 8'h3C, 1'b0, 1'b1, 4'd5},  // R5 data write
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b0, 1'b1, 4'd5},  // R5 command value as data
    {1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 done clears
    {1'b1, 1'b0, 15'h1234, 8'h3C, 1'b0, 1'b0, 4'd4},  // R4 no prefix
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 15'h2AAA, 8'h56, 1'b0, 1'b0, 4'd4},  // R4 bad data
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b0, 1'b0, 4'd4},  // R4 restarted
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 15'h5554, 8'hA0, 1'b0, 1'b0, 4'd4},  // R4 bad address
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b0, 4'd4},  // R4 restarted
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 4'd3},
    {1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 done mid prefix
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b0, 4'd7},  // R7 progress gone
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b1, 15'h5555, 8'hA0, 1'b0, 1'b0, 4'd8},  // R8 done with last step
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b0, 1'b0, 4'd8},  // R8 not advanced
    {1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 15'h5555, 8'hA0, 1'b1, 1'b1, 4'd2},
    {1'b1, 1'b1, 15'h0BCD, 8'h11, 1'b0, 1'b0, 4'd6}   // R6 done with data strobe
  };

  task automatic check(input logic act, input logic exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [30:0] v);
    @(negedge clk);
    {stb, done, addr, data} = v[30:6];
    #1 check(cmd, v[5], int'(v[3:0]), "cmd_o");
    @(posedge clk);
    #1 check(auth, v[4], int'(v[3:0]), "auth_o");
    stb = 1'b0;
    done = 1'b0;
  endtask

  initial begin
    #5 check(auth, 1'b0, 1, "auth_o in reset");  // R1
    check(cmd, 1'b0, 1, "cmd_o in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 check(auth, 1'b0, 1, "auth_o after reset");  // R1
    for (int i = 0; i < NV; i++) apply(VEC[i]);
    // arm, then reset mid-window: R1
    apply({1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd3});
    apply({1'b1, 1'b0, 15'h2AAA, 8'h55, 1'b1, 1'b0, 4'd3});
    apply({1'b1, 1'b0, 15'h5555, 8'hA0, 1'b1, 1'b1, 4'd2});
    // long idle while armed: R6
    repeat (20) @(negedge clk);
    check(auth, 1'b1, 6, "auth_o after idle");
    rst_n = 1'b0;
    #1 check(auth, 1'b0, 1, "auth_o on async reset");
    @(negedge clk);
    rst_n = 1'b1;
    // progress lost over reset: R1
    apply({1'b1, 1'b0, 15'h5555, 8'hAA, 1'b1, 1'b0, 4'd1});
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule